// File: doc/BRIEF.md
# Bus Master Ownership Controller

This block sits beside one bus master and handles how that master gains and gives up a shared bus. A central arbiter, which is not part of this block, decides the order of the masters. The block raises a request when the local core has transfers waiting. Once granted, it treats itself as master-elect and waits until the shared busy line has been seen free for a configurable number of clocks. Only then does it drive busy and acknowledge, and the core may start transfers only after that acknowledge.

When the arbiter withdraws the grant, the owner first finishes the access in progress and then drops busy and acknowledge together. An atomic read-modify-write sequence raises a lock output, and the bus is kept through the whole sequence even if the grant is lost. Two control bits let software hold the request permanently or hold the lock permanently. A status word reports both bits and whether this device owns the bus.

Top module: `bus_own_ctrl`

## Requirements
- R1: While rst_ni is low, bus_req_o, busy_o, ack_o, lock_o and stat_o are all zero, and both control bits are cleared.
- R2: bus_req_o equals xfer_pend_i OR the request-keep bit, in the same cycle, with no register in the path from xfer_pend_i.
- R3: A cfg_we_i write takes cfg_wdata_i[0] as the request-keep bit. While that bit is set, bus_req_o stays high with no transfer pending.
- R4: Ownership (busy_o and ack_o both high) is claimed only after bus_grant_i has been sampled high on entry to master-elect. busy_i must then be sampled low on SETTLE_CYC consecutive clock edges with the grant still high. A high sample of busy_i restarts the count. busy_o and ack_o are always equal.
- R5: If the grant is sampled low while the block is master-elect, the block returns to requesting without claiming the bus. A later grant starts a fresh settle window.
- R6: An owner keeps the bus while bus_grant_i is high. On the first edge with the grant low, xfer_busy_i low, rmw_i low and the lock-keep bit clear, it drops busy_o and ack_o.
- R7: While it owns the bus, rmw_i raises lock_o in the same cycle. The bus is not released while rmw_i is high. Once lock_o is raised, it stays high until ownership ends and falls in the same cycle as ack_o.
- R8: A cfg_we_i write takes cfg_wdata_i[1] as the lock-keep bit. While that bit is set, lock_o is high for the whole time the block owns the bus, and the block does not release the bus.
- R9: stat_o[0] shows the request-keep bit, stat_o[1] shows the lock-keep bit, and stat_o[2] is high exactly while ack_o is high.
- R10: lock_o is never high unless ack_o is high. rmw_i has no effect on lock_o while the block does not own the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_pend_i | input | 1 | Core has bus transfers waiting |
| xfer_busy_i | input | 1 | A bus access is in progress |
| rmw_i | input | 1 | An atomic read-modify-write sequence is active |
| bus_req_o | output | 1 | Request to the central arbiter |
| bus_grant_i | input | 1 | Grant from the central arbiter |
| busy_i | input | 1 | Sensed state of the shared busy line |
| busy_o | output | 1 | Drive of the shared busy line |
| lock_o | output | 1 | Bus lock |
| ack_o | output | 1 | Ownership acknowledge to the core |
| cfg_we_i | input | 1 | Control bit write strobe |
| cfg_wdata_i | input | 2 | Control bits: [0] request keep, [1] lock keep |
| stat_o | output | 3 | Status: [0] request keep, [1] lock keep, [2] owner |

## Verification
The bench builds the block with SETTLE_CYC set to 2, not the default of 1. With that value the settle window spans more than one edge. This makes it possible to test a busy_i pulse in the middle of the window restarting the count, and a grant loss part-way through the master-elect phase. Random grant, busy and lock traffic is checked cycle by cycle against run lengths and conditions that the bench tracks itself. Directed cases pin down the exact claim and release edges.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_ELECT = 3'd2,
    ST_OWN   = 3'd3,
    ST_REL   = 3'd4
  } own_state_e;

  localparam int CFG_W         = 2;
  localparam int REQ_KEEP_BIT  = 0;
  localparam int LOCK_KEEP_BIT = 1;
  localparam int STAT_W        = 3;
  localparam int STAT_OWN_BIT  = 2;
endpackage

// File: rtl/bus_own_cfg.sv
module bus_own_cfg
  import bus_own_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic             req_keep_o,
  output logic             lock_keep_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= wdata_i;
  end

  assign req_keep_o  = cfg_q[REQ_KEEP_BIT];
  assign lock_keep_o = cfg_q[LOCK_KEEP_BIT];
endmodule

// File: rtl/bus_own_settle.sv
module bus_own_settle #(
  parameter int SETTLE_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic busy_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!arm_i || busy_i)    cnt_q <= '0;
    else if (cnt_q < LIMIT)       cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = arm_i && !busy_i && (cnt_q >= LIMIT);

  // R4
  busy_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (cnt_q == '0));
endmodule

// File: rtl/bus_own_fsm.sv
module bus_own_fsm
  import bus_own_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic need_i,
  input  logic grant_i,
  input  logic settled_i,
  input  logic xfer_busy_i,
  input  logic rmw_i,
  input  logic lock_keep_i,
  output logic arm_o,
  output logic owner_o,
  output logic lock_o
);
  own_state_e state_q, state_d;
  logic       lock_hold_q;
  logic       release_ok;

  assign release_ok = !grant_i && !xfer_busy_i && !rmw_i && !lock_keep_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (need_i) state_d = ST_REQ;
      ST_REQ: begin
        if (!need_i)      state_d = ST_IDLE;
        else if (grant_i) state_d = ST_ELECT;
      end
      ST_ELECT: begin
        if (!grant_i)       state_d = need_i ? ST_REQ : ST_IDLE;
        else if (settled_i) state_d = ST_OWN;
      end
      ST_OWN:   if (release_ok) state_d = ST_REL;
      ST_REL:   state_d = need_i ? ST_REQ : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      lock_hold_q <= 1'b0;
    end else begin
      state_q <= state_d;
      // lock sticks until the bus is handed back
      if (state_q == ST_OWN && state_d == ST_OWN)
        lock_hold_q <= lock_hold_q | rmw_i | lock_keep_i;
      else
        lock_hold_q <= 1'b0;
    end
  end

  assign arm_o   = (state_q == ST_ELECT);
  assign owner_o = (state_q == ST_OWN);
  assign lock_o  = owner_o && (rmw_i || lock_keep_i || lock_hold_q);

  // R5
  elect_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_o && !grant_i) |=> !owner_o);

  // R4
  own_from_elect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(owner_o) |-> $past(arm_o));
endmodule

// File: rtl/bus_own_ctrl.sv
module bus_own_ctrl
  import bus_own_pkg::*;
#(
  parameter int SETTLE_CYC = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_pend_i,
  input  logic              xfer_busy_i,
  input  logic              rmw_i,
  output logic              bus_req_o,
  input  logic              bus_grant_i,
  input  logic              busy_i,
  output logic              busy_o,
  output logic              lock_o,
  output logic              ack_o,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic [STAT_W-1:0] stat_o
);
  logic req_keep, lock_keep;
  logic arm, settled, owner;

  bus_own_cfg u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .wdata_i     (cfg_wdata_i),
    .req_keep_o  (req_keep),
    .lock_keep_o (lock_keep)
  );

  assign bus_req_o = xfer_pend_i | req_keep;

  bus_own_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (arm),
    .busy_i (busy_i),
    .done_o (settled)
  );

  bus_own_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .need_i      (bus_req_o),
    .grant_i     (bus_grant_i),
    .settled_i   (settled),
    .xfer_busy_i (xfer_busy_i),
    .rmw_i       (rmw_i),
    .lock_keep_i (lock_keep),
    .arm_o       (arm),
    .owner_o     (owner),
    .lock_o      (lock_o)
  );

  assign busy_o = owner;
  assign ack_o  = owner;

  always_comb begin
    stat_o                = '0;
    stat_o[REQ_KEEP_BIT]  = req_keep;
    stat_o[LOCK_KEEP_BIT] = lock_keep;
    stat_o[STAT_OWN_BIT]  = owner;
  end

  // R4
  claim_free_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> ($past(bus_grant_i) && !$past(busy_i)));

  // R6
  hold_while_granted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && bus_grant_i) |=> ack_o);

  // R7
  rmw_keeps_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && rmw_i) |=> ack_o);

  // R7
  lock_falls_with_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> !ack_o);

  // R8
  lock_keep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && lock_keep) |=> ack_o);

  // R10
  lock_only_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> ack_o);
endmodule

// File: tb/sim_bus_own_ctrl.sv
module sim_bus_own_ctrl;
  localparam int S = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pend = 0, xb = 0, rmw = 0, grant = 0, busy_in = 0, we = 0;
  logic [1:0] wd = '0;
  logic bus_req_o, busy_o, lock_o, ack_o;
  logic [2:0] stat_o;

  int errors = 0, checks = 0;
  logic rk = 0, lk = 0, prev_ack = 0, prev_lock = 0;
  int grun = 0, brun = 0;

  always #10 clk = ~clk;

  bus_own_ctrl #(.SETTLE_CYC(S)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .xfer_pend_i(pend), .xfer_busy_i(xb),
    .rmw_i(rmw), .bus_req_o(bus_req_o), .bus_grant_i(grant), .busy_i(busy_in),
    .busy_o(busy_o), .lock_o(lock_o), .ack_o(ack_o), .cfg_we_i(we),
    .cfg_wdata_i(wd), .stat_o(stat_o)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic release_due(input logic g, x, r, l);
    return !g && !x && !r && !l;
  endfunction

  // one clock: edge-level checks at the following negedge
  task automatic step();
    logic old_lk;
    @(posedge clk);
    old_lk = lk;
    grun = grant ? grun + 1 : 0;
    brun = (!busy_in) ? brun + 1 : 0;
    if (we) begin rk = wd[0]; lk = wd[1]; end
    @(negedge clk);
    chk(busy_o == ack_o, "R4 busy_o==ack_o", busy_o, ack_o);
    chk(stat_o == {ack_o, lk, rk}, "R9 stat", stat_o, {ack_o, lk, rk});
    if (!prev_ack && ack_o)
      chk(grun >= S + 1 && brun >= S, "R4 claim window", brun, S);
    if (prev_ack)
      chk(ack_o == !release_due(grant, xb, rmw, old_lk), "R6 release", ack_o,
          !release_due(grant, xb, rmw, old_lk));
    if (prev_lock && !lock_o)
      chk(!ack_o, "R7 lock falls with ack", ack_o, 0);
    prev_ack = ack_o;
    prev_lock = lock_o;
  endtask

  task automatic comb_chk();
    #1;
    chk(bus_req_o == (pend | rk), "R2 request", bus_req_o, pend | rk);
    chk(!lock_o || ack_o, "R10 lock without ack", lock_o, 0);
    if (!ack_o) chk(!lock_o, "R10 rmw ignored when not owner", lock_o, 0);
    prev_lock = lock_o;
  endtask

  task automatic acquire();
    grant = 1; busy_in = 0;
    for (int i = 0; i < 12 && !ack_o; i++) step();
    chk(ack_o, "R4 acquire", ack_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset
    #35;
    chk({bus_req_o, busy_o, ack_o, lock_o} == 0, "R1 outputs in reset",
        {bus_req_o, busy_o, ack_o, lock_o}, 0);
    chk(stat_o == 0, "R1 stat in reset", stat_o, 0);
    @(negedge clk); rst_ni = 1;

    // R2 request follows pending in the same cycle
    pend = 1; comb_chk();
    chk(bus_req_o, "R2 immediate", bus_req_o, 1);
    step();                               // IDLE -> REQ
    grant = 1; busy_in = 1;
    step(); step(); step();               // elect, busy still held
    chk(!ack_o, "R4 waits for busy", ack_o, 0);
    busy_in = 0; step();
    chk(!ack_o, "R4 one low sample", ack_o, 0);
    busy_in = 1; step();                  // restart window
    busy_in = 0; step();
    chk(!ack_o, "R4 restart after busy pulse", ack_o, 0);
    step();
    chk(ack_o && busy_o, "R4 claimed", ack_o, 1);

    // R6 finish access before release
    grant = 0; xb = 1; step();
    chk(ack_o, "R6 access in progress", ack_o, 1);
    xb = 0; step();
    chk(!ack_o && !busy_o, "R6 released", ack_o, 0);

    // R5 grant lost while master-elect
    step();                               // REL -> REQ
    grant = 1; step();                    // -> ELECT
    grant = 0; step(); step();
    chk(!ack_o, "R5 no claim on lost grant", ack_o, 0);
    grant = 1; step(); step();
    chk(!ack_o, "R5 fresh window", ack_o, 0);
    step();
    chk(ack_o, "R5 claim after fresh window", ack_o, 1);

    // R7 read-modify-write lock
    rmw = 1; comb_chk();
    chk(lock_o, "R7 lock same cycle", lock_o, 1);
    grant = 0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(ack_o && lock_o, "R7 bus held in rmw", ack_o, 1);
    end
    rmw = 0; comb_chk();
    chk(lock_o, "R7 lock held to release", lock_o, 1);
    step();
    chk(!ack_o && !lock_o, "R7 lock and ack fall", lock_o, 0);

    // R8 lock keep
    we = 1; wd = 2'b10; step(); we = 0;
    acquire();
    comb_chk();
    chk(lock_o, "R8 lock while owner", lock_o, 1);
    grant = 0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(ack_o, "R8 no release with lock keep", ack_o, 1);
    end
    we = 1; wd = 2'b00; step(); we = 0;
    chk(ack_o, "R8 write edge still held", ack_o, 1);
    step();
    chk(!ack_o && !lock_o, "R8 release after clear", ack_o, 0);

    // R3 request keep
    pend = 0; step(); step();
    we = 1; wd = 2'b01; step(); we = 0; comb_chk();
    chk(bus_req_o, "R3 request kept", bus_req_o, 1);
    we = 1; wd = 2'b00; step(); we = 0; comb_chk();
    chk(!bus_req_o, "R3 request dropped", bus_req_o, 0);

    // R10 rmw outside ownership
    rmw = 1; comb_chk();
    chk(!lock_o, "R10 no lock when idle", lock_o, 0);
    rmw = 0;

    // random mix
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < 4000; n++) begin
      step();
      pend    = ($urandom % 4) != 0;
      xb      = ack_o && (($urandom % 3) == 0);
      rmw     = ack_o && (($urandom % 5) == 0);
      if (($urandom % 6) == 0) grant = ~grant;
      busy_in = !ack_o && (($urandom % 3) == 0);
      we      = ($urandom % 40) == 0;
      wd      = {(($urandom % 4) == 0), 1'($urandom)};
      comb_chk();
    end
    we = 0; lk = lk; step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule